// File: doc/BRIEF.md
# Capture/Compare Interval Timer

A prescaled up-counter with a bank of capture/compare channels. Each channel holds one value. A single-cycle capture pulse loads the live count into that value. The channel emits a one-cycle compare pulse when the counter steps onto the value. Start, stop and clear arrive as single-cycle task pulses. Per-channel hardware links route a compare straight into the clear action, the stop action, or both, so a one-shot timeout or a periodic wrap needs no software service.

A simple register port configures the block. Through it software sets the divide ratio, the channel values, the two link masks and the interrupt enables. It also reads back the count, the run state and the sticky compare flags. The interrupt output is high while any enabled flag is set. Software removes a flag by writing zero to its bit.

Top module: `cc_timer`

## Requirements
- R1: The counter is CNT_W bits wide (default 32). It steps up by one on each tick and wraps from all-ones to 0.
- R2: Address 0 holds the divide exponent p in bits [3:0]. A tick occurs once every 2^p clock cycles while running. The first tick comes 2^p cycles after the start edge. Writes of values above 9 are ignored.
- R3: NUM_CH is 4 or 6. The value of channel n is read and written at address 8+n, so the 6-channel build exposes channels 4 and 5 at addresses 12 and 13.
- R4: A capture pulse on channel n copies the pre-edge count into that channel's value, and the copy is readable in the next cycle. A capture wins over a register write to the same channel in the same cycle.
- R5: A channel's compare output pulses for one cycle in the cycle after the counter steps onto that channel's value. It never pulses while the counter is held stopped on that value.
- R6: Bit n of address 1 links compare n to clear, and bit n of address 2 links compare n to stop. The linked action takes effect at the next edge. With both bits set the timer halts at 0 (one-shot). With only the clear bit set, the period is value+1 ticks.
- R7: After reset the timer is stopped, the count is 0, the divide exponent is 0, and all link masks, enables, flags and channel values are 0.
- R8: Writing 1s to address 3 sets interrupt enable bits, and writing 1s to address 4 clears them. Zero bits leave enables unchanged, and either address reads back the enables. The irq output is the OR over channels of flag AND enable.
- R9: A write to the divide exponent while the timer is running is ignored.
- R10: A clear pulse sets the count to 0 at the next edge and wins over a tick. A clear and a start in the same cycle restart counting from 0.
- R11: Address 5 reads the sticky compare flags. A flag is set by its channel's compare pulse and stays set until software writes 0 to its bit; writing 1 keeps it. A compare in the same cycle as the clearing write wins.
- R12: A stop pulse wins over a start pulse in the same cycle. Address 6 reads the count, and bit 0 of address 7 reads the run state. A stopped counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock, the undivided tick source |
| rst_n | input | 1 | Synchronous active-low reset |
| task_start | input | 1 | Single-cycle start pulse |
| task_stop | input | 1 | Single-cycle stop pulse |
| task_clear | input | 1 | Single-cycle clear pulse |
| task_capture | input | NUM_CH | Per-channel capture pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for write and read |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Register read data for reg_addr (combinational) |
| cmp_event | output | NUM_CH | Per-channel compare pulses |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs a cycle-level reference built from the requirements. Every cycle it compares the compare pulses, the interrupt and the read data at the current address. That reference is driven by seeded random mixes of tasks, captures and register writes with small channel values, so compares, link actions and same-cycle collisions (stop with start, capture with write, compare with flag clear) occur often.

Directed cases pin absolute timing. A divide exponent of 3 against 9 separates tick spacing from an off-by-one in the divider. A one-shot at value 10 shows that the compare lands exactly ten ticks after start and that the timer then stops at 0. A periodic wrap at value 4 distinguishes period value+1 from value. A full wrap of a 12-bit build shows the all-ones to 0 step and the compare on 0. A channel value written onto a held count shows that holding does not fire a compare.

// File: rtl/cct_pkg.sv
// Shared constants for the capture/compare timer: register map and
// prescaler limits. Assumes a 5-bit register address space.
package cct_pkg;
    localparam int PRE_W   = 4;
    localparam int PRE_MAX = 9;
    localparam int DIV_W   = PRE_MAX;
    localparam int ADDR_W  = 5;

    localparam logic [ADDR_W-1:0] A_PRESCALE  = 5'd0;
    localparam logic [ADDR_W-1:0] A_LINK_CLR  = 5'd1;
    localparam logic [ADDR_W-1:0] A_LINK_STOP = 5'd2;
    localparam logic [ADDR_W-1:0] A_IEN_SET   = 5'd3;
    localparam logic [ADDR_W-1:0] A_IEN_CLR   = 5'd4;
    localparam logic [ADDR_W-1:0] A_FLAGS     = 5'd5;
    localparam logic [ADDR_W-1:0] A_COUNT     = 5'd6;
    localparam logic [ADDR_W-1:0] A_STATUS    = 5'd7;
    localparam logic [ADDR_W-1:0] A_CH_BASE   = 5'd8;
endpackage

// File: rtl/cct_prescaler.sv
// Tick divider: issues one tick every 2^pre cycles while running.
// Assumes pre <= PRE_MAX; the divider restarts on clear and while stopped.
module cct_prescaler
    import cct_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] pre,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Terminal count for the selected ratio.
    always_comb mask = DIV_W'((32'd1 << pre) - 32'd1);

    assign tick = run && (div_q == mask);

    // Divider state: counts up to the mask, restarts on tick, clear or idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (restart || !run || tick)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/cct_counter.sv
// Main count and run state. Stop wins over start; clear wins over a tick.
// Assumes stop/clear already include the compare-link contributions.
module cct_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             stop,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt_q,
    output logic             run_q,
    output logic             stepped_q
);
    // Run flag: stop has priority over start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else if (stop)
            run_q <= 1'b0;
        else if (start)
            run_q <= 1'b1;
    end

    // Count register with natural wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    // Marks a cycle whose count was reached by a tick, not by clear or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stepped_q <= 1'b0;
        else
            stepped_q <= tick && !clear;
    end
endmodule

// File: rtl/cct_channel.sv
// One capture/compare channel: value register, compare pulse and sticky flag.
// Assumes capture wins over a register write in the same cycle.
module cct_channel #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             stepped,
    input  logic             capture,
    input  logic             val_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             flag_wr,
    input  logic             flag_keep,
    output logic [CNT_W-1:0] val_q,
    output logic             hit,
    output logic             flag_q
);
    assign hit = stepped && (cnt == val_q);

    // Channel value: capture of the live count, else software write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            val_q <= '0;
        else if (capture)
            val_q <= cnt;
        else if (val_wr)
            val_q <= wdata;
    end

    // Sticky flag: set by a compare, cleared by writing 0; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (hit)
            flag_q <= 1'b1;
        else if (flag_wr && !flag_keep)
            flag_q <= 1'b0;
    end
endmodule

// File: rtl/cc_timer.sv
// Capture/compare timer top: register file, compare-to-clear/stop links,
// interrupt enables and read mux. Assumes NUM_CH is 4 or 6 and CNT_W >= 6.
module cc_timer
    import cct_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              task_start,
    input  logic              task_stop,
    input  logic              task_clear,
    input  logic [NUM_CH-1:0] task_capture,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic [NUM_CH-1:0] cmp_event,
    output logic              irq
);
    logic [PRE_W-1:0]  pre_q;
    logic [NUM_CH-1:0] lclr_q, lstop_q, ien_q, flag_q;
    logic [CNT_W-1:0]  cc_bank [NUM_CH];
    logic [CNT_W-1:0]  cnt_q;
    logic              run_q, stepped_q, tick;
    logic              clear_all, stop_all;
    logic              flag_wr;

    assign clear_all = task_clear || |(cmp_event & lclr_q);
    assign stop_all  = task_stop  || |(cmp_event & lstop_q);
    assign flag_wr   = reg_wr && (reg_addr == A_FLAGS);
    assign irq       = |(flag_q & ien_q);

    cct_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .restart (clear_all),
        .pre     (pre_q),
        .tick    (tick)
    );

    cct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .start     (task_start),
        .stop      (stop_all),
        .clear     (clear_all),
        .cnt_q     (cnt_q),
        .run_q     (run_q),
        .stepped_q (stepped_q)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        cct_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt       (cnt_q),
            .stepped   (stepped_q),
            .capture   (task_capture[g]),
            .val_wr    (reg_wr && (reg_addr == A_CH_BASE + ADDR_W'(g))),
            .wdata     (reg_wdata),
            .flag_wr   (flag_wr),
            .flag_keep (reg_wdata[g]),
            .val_q     (cc_bank[g]),
            .hit       (cmp_event[g]),
            .flag_q    (flag_q[g])
        );
    end

    // Divide exponent: accepted only while stopped and in range.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (reg_wr && reg_addr == A_PRESCALE && !run_q
                 && reg_wdata <= CNT_W'(PRE_MAX))
            pre_q <= reg_wdata[PRE_W-1:0];
    end

    // Compare-link masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lclr_q  <= '0;
            lstop_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_LINK_CLR)  lclr_q  <= reg_wdata[NUM_CH-1:0];
            if (reg_addr == A_LINK_STOP) lstop_q <= reg_wdata[NUM_CH-1:0];
        end
    end

    // Interrupt enables through separate set and clear addresses.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien_q <= '0;
        else if (reg_wr && reg_addr == A_IEN_SET)
            ien_q <= ien_q | reg_wdata[NUM_CH-1:0];
        else if (reg_wr && reg_addr == A_IEN_CLR)
            ien_q <= ien_q & ~reg_wdata[NUM_CH-1:0];
    end

    // Read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_PRESCALE:             reg_rdata = CNT_W'(pre_q);
            A_LINK_CLR:             reg_rdata = CNT_W'(lclr_q);
            A_LINK_STOP:            reg_rdata = CNT_W'(lstop_q);
            A_IEN_SET, A_IEN_CLR:   reg_rdata = CNT_W'(ien_q);
            A_FLAGS:                reg_rdata = CNT_W'(flag_q);
            A_COUNT:                reg_rdata = cnt_q;
            A_STATUS:               reg_rdata = CNT_W'(run_q);
            default: begin
                for (int n = 0; n < NUM_CH; n++)
                    if (reg_addr == A_CH_BASE + ADDR_W'(n))
                        reg_rdata = cc_bank[n];
            end
        endcase
    end
endmodule

// File: rtl/cct_checker.sv
// Property checker for cc_timer, attached by bind. Observes ports and the
// internal count, run state, divide exponent, link masks, flags and values.
module cct_checker
    import cct_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              task_stop,
    input logic              task_clear,
    input logic [NUM_CH-1:0] task_capture,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [NUM_CH-1:0] cmp_event,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              run_q,
    input logic [PRE_W-1:0]  pre_q,
    input logic [NUM_CH-1:0] lstop_q,
    input logic [NUM_CH-1:0] flag_q,
    input logic [CNT_W-1:0]  cc_bank [NUM_CH]
);
    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        task_stop |=> !run_q); // R12

    AST_HELD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !task_clear && cmp_event == '0) |=> $stable(cnt_q)); // R12

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        task_clear |=> cnt_q == '0); // R10

    AST_NO_IDLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_event != '0) |-> $past(run_q)); // R5

    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmp_event & lstop_q) != '0) |=> !run_q); // R6

    AST_PRE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run_q) |-> $stable(pre_q)); // R9

    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= PRE_W'(PRE_MAX)); // R2

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_q != '0)); // R8

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        AST_CAPTURE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
            task_capture[g] |=> cc_bank[g] == $past(cnt_q)); // R4

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[g] && !(reg_wr && reg_addr == A_FLAGS)) |=> flag_q[g]); // R11
    end
endmodule

bind cc_timer cct_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .task_stop    (task_stop),
    .task_clear   (task_clear),
    .task_capture (task_capture),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .cmp_event    (cmp_event),
    .irq          (irq),
    .cnt_q        (cnt_q),
    .run_q        (run_q),
    .pre_q        (pre_q),
    .lstop_q      (lstop_q),
    .flag_q       (flag_q),
    .cc_bank      (cc_bank)
);

// File: tb/cc_timer_bench.sv
module cc_timer_bench;
    localparam int NCH = 6;
    localparam int CW  = 12;
    localparam int WATCH_CYC = 150000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           t_start = 0, t_stop = 0, t_clear = 0;
    logic [NCH-1:0] t_cap = '0;
    logic           wr = 0;
    logic [4:0]     addr = '0;
    logic [CW-1:0]  wdata = '0;
    logic [CW-1:0]  rdata;
    logic [NCH-1:0] cmp_event;
    logic           irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cc_timer #(.NUM_CH(NCH), .CNT_W(CW)) u_cc_timer (
        .clk(clk), .rst_n(rst_n),
        .task_start(t_start), .task_stop(t_stop), .task_clear(t_clear),
        .task_capture(t_cap),
        .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
        .cmp_event(cmp_event), .irq(irq)
    );

    // Reference state, built from the requirements.
    logic           m_run, m_step;
    logic [CW-1:0]  m_cnt;
    int             m_div, m_pre;
    logic [CW-1:0]  m_cc [NCH];
    logic [NCH-1:0] m_lclr, m_lstop, m_ien, m_flag;

    function automatic logic [NCH-1:0] m_events();
        logic [NCH-1:0] e;
        for (int n = 0; n < NCH; n++) e[n] = m_step && (m_cnt == m_cc[n]);
        return e;
    endfunction

    function automatic logic [CW-1:0] m_read(input logic [4:0] a);
        case (a)
            5'd0: return CW'(m_pre);
            5'd1: return CW'(m_lclr);
            5'd2: return CW'(m_lstop);
            5'd3, 5'd4: return CW'(m_ien);
            5'd5: return CW'(m_flag);
            5'd6: return m_cnt;
            5'd7: return CW'(m_run);
            default: begin
                for (int n = 0; n < NCH; n++) if (int'(a) == 8 + n) return m_cc[n];
                return '0;
            end
        endcase
    endfunction

    always @(posedge clk) begin : model_step
        logic [NCH-1:0] ev;
        logic tk, clr, stp;
        if (!rst_n) begin
            m_run = 0; m_step = 0; m_cnt = '0; m_div = 0; m_pre = 0;
            m_lclr = '0; m_lstop = '0; m_ien = '0; m_flag = '0;
            for (int n = 0; n < NCH; n++) m_cc[n] = '0;
        end else begin
            ev  = m_events();
            tk  = m_run && (m_div == (1 << m_pre) - 1);
            clr = t_clear || |(ev & m_lclr);
            stp = t_stop  || |(ev & m_lstop);
            for (int n = 0; n < NCH; n++) begin
                if (t_cap[n]) m_cc[n] = m_cnt;
                else if (wr && int'(addr) == 8 + n) m_cc[n] = wdata;
            end
            if (wr && addr == 5'd5) m_flag = (m_flag & wdata[NCH-1:0]) | ev;
            else m_flag = m_flag | ev;
            if (wr && addr == 5'd0 && !m_run && int'(wdata) <= 9) m_pre = int'(wdata);
            if (wr && addr == 5'd1) m_lclr = wdata[NCH-1:0];
            if (wr && addr == 5'd2) m_lstop = wdata[NCH-1:0];
            if (wr && addr == 5'd3) m_ien = m_ien | wdata[NCH-1:0];
            if (wr && addr == 5'd4) m_ien = m_ien & ~wdata[NCH-1:0];
            m_div = (clr || !m_run || tk) ? 0 : m_div + 1;
            m_step = tk && !clr;
            if (clr) m_cnt = '0;
            else if (tk) m_cnt = m_cnt + 1'b1;
            m_run = stp ? 1'b0 : (t_start ? 1'b1 : m_run);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the reference (R5, R8, R11 and reads).
    always @(negedge clk) begin
        if (rst_n) begin
            #2;
            chk("R5 compare pulses vs reference", 32'(cmp_event), 32'(m_events()));
            chk("R8 irq vs reference", 32'(irq), 32'(|(m_flag & m_ien)));
            chk("R3 read data vs reference", 32'(rdata), 32'(m_read(addr)));
        end
    end

    task automatic wr_reg(input logic [4:0] a, input logic [CW-1:0] d);
        wr = 1; addr = a; wdata = d;
        @(negedge clk);
        wr = 0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [CW-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse(input logic s, input logic p, input logic c, input logic [NCH-1:0] cap);
        t_start = s; t_stop = p; t_clear = c; t_cap = cap;
        @(negedge clk);
        t_start = 0; t_stop = 0; t_clear = 0; t_cap = '0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(WATCH_CYC * 20);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired (R12 run did not complete) actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin : main
        logic [CW-1:0] v;
        int first, hits, dummy;
        dummy = $urandom(32'd2024);
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R7 reset state
        rd_reg(5'd6, v); chk("R7 count after reset", v, 0);
        rd_reg(5'd7, v); chk("R7 stopped after reset", v, 0);
        rd_reg(5'd1, v); chk("R7 clear links off", v, 0);
        rd_reg(5'd2, v); chk("R7 stop links off", v, 0);
        chk("R7 irq low", irq, 0);

        // R8 enable set/clear
        wr_reg(5'd3, 12'b000101);
        wr_reg(5'd4, 12'b000001);
        rd_reg(5'd3, v); chk("R8 enable set/clear", v, 12'b000100);
        wr_reg(5'd4, 12'h3F);

        // R2 divide by 8: count 5 after 40 cycles
        wr_reg(5'd0, 12'd3);
        rd_reg(5'd0, v); chk("R2 exponent readback", v, 3);
        pulse(1, 0, 0, '0);
        repeat (40) @(negedge clk);
        rd_reg(5'd6, v); chk("R2 count at divide 8", v, 5);
        wr_reg(5'd0, 12'd5);
        rd_reg(5'd0, v); chk("R9 write while running ignored", v, 3);
        pulse(0, 1, 0, '0);
        wr_reg(5'd0, 12'd10);
        rd_reg(5'd0, v); chk("R2 out-of-range exponent ignored", v, 3);

        // R10 clear with start, R2 divide by 512
        wr_reg(5'd0, 12'd9);
        pulse(1, 0, 1, '0);
        repeat (1024) @(negedge clk);
        rd_reg(5'd6, v); chk("R10 restart from 0 at divide 512", v, 2);
        pulse(0, 1, 0, '0);

        // R12 stop wins over start
        pulse(1, 1, 0, '0);
        rd_reg(5'd7, v); chk("R12 stop beats start", v, 0);
        repeat (3) @(negedge clk);
        rd_reg(5'd6, v); chk("R12 stopped count holds", v, 2);

        // R4 capture of a held count; R5 no compare on held value
        pulse(0, 0, 0, 6'b000100);
        rd_reg(5'd10, v); chk("R4 capture channel 2", v, 2);
        wr_reg(5'd11, 12'd2);
        repeat (5) @(negedge clk);
        rd_reg(5'd5, v); chk("R5 no compare while held", v & 12'h8, 0);

        // R6 one-shot at value 10
        wr_reg(5'd0, 12'd0);
        pulse(0, 0, 1, '0);
        wr_reg(5'd5, 12'd0);
        wr_reg(5'd8, 12'd10);
        wr_reg(5'd1, 12'd1);
        wr_reg(5'd2, 12'd1);
        wr_reg(5'd3, 12'd1);
        pulse(1, 0, 0, '0);
        first = 0;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk); #1;
            if (cmp_event[0] && first == 0) first = k;
        end
        chk("R5 compare 10 ticks after start", first, 10);
        rd_reg(5'd6, v); chk("R6 one-shot ends at 0", v, 0);
        rd_reg(5'd7, v); chk("R6 one-shot stops", v, 0);
        chk("R8 irq from enabled flag", irq, 1);
        repeat (5) @(negedge clk);
        rd_reg(5'd5, v); chk("R11 flag sticky", v & 12'h1, 1);
        wr_reg(5'd5, 12'hFFE);
        rd_reg(5'd5, v); chk("R11 write 0 clears flag", v & 12'h1, 0);
        chk("R8 irq drops with flag", irq, 0);

        // R6 periodic: value 4 with clear link only gives period 5
        wr_reg(5'd8, 12'd4);
        wr_reg(5'd2, 12'd0);
        pulse(1, 0, 0, '0);
        hits = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk); #1;
            if (cmp_event[0]) hits++;
        end
        chk("R6 periodic compare count", hits, 4);
        pulse(0, 1, 0, '0);
        wr_reg(5'd1, 12'd0);

        // R1 wrap of the 12-bit build
        wr_reg(5'd9, 12'd0);
        pulse(1, 0, 1, '0);
        repeat (4095) @(negedge clk);
        rd_reg(5'd6, v); chk("R1 count before wrap", v, 12'hFFF);
        @(negedge clk);
        rd_reg(5'd6, v); chk("R1 count wraps to 0", v, 0);
        #1 chk("R1 compare on wrap to 0", cmp_event[1], 1);
        pulse(0, 1, 0, '0);

        // R3 upper channels
        wr_reg(5'd13, 12'h123);
        rd_reg(5'd13, v); chk("R3 channel 5 write", v, 12'h123);
        pulse(0, 0, 0, 6'b100000);
        rd_reg(5'd6, v);
        begin
            logic [CW-1:0] c5;
            rd_reg(5'd13, c5); chk("R4 capture channel 5", c5, v);
        end

        // Seeded random mix, checked every cycle against the reference
        for (int i = 0; i < 4000; i++) begin
            logic [4:0] a;
            t_start = ($urandom % 12) == 0;
            t_stop  = ($urandom % 30) == 0;
            t_clear = ($urandom % 30) == 0;
            for (int n = 0; n < NCH; n++) t_cap[n] = ($urandom % 40) == 0;
            a = 5'($urandom % 14);
            addr = a;
            wr = ($urandom % 4) == 0;
            if (a == 5'd0) wdata = CW'($urandom % 12);
            else if (a >= 5'd8) wdata = CW'($urandom % 24);
            else wdata = CW'($urandom);
            @(negedge clk);
        end
        t_start = 0; t_stop = 0; t_clear = 0; t_cap = '0; wr = 0;
        @(negedge clk);
        #3;
        summary();
        $finish;
    end
endmodule